// File: doc/BRIEF.md
# Replication-aware victim selector

This block chooses which way of one set in a private L2 cache to evict when a new line must be filled. The cache shares data with peer caches, so each way holds a valid bit, a sharing-status bit and an LRU age. The status bit marks the line as either a singlet, meaning it is the only copy on the chip, or a replicate, meaning another cache also holds a copy.

The victim is chosen so that the only on-chip copy of a line is kept whenever possible. A free way is used first. Failing that, the oldest replicate is chosen, because a copy of it still exists elsewhere. Failing that, the oldest singlet is chosen. When the victim is a valid singlet, the block raises a spill flag so the caller can push the line to a peer bank instead of dropping it.

The victim outputs are combinational and follow the current state. Hits and fills refresh the recency order on the next clock edge. Snoop events from peer caches can set or clear the status bit of a single way.

Top module: `repl_victim_sel`

## Requirements
- R1: After reset all ways are invalid, so the victim is way 0 with `victim_valid_o`=0 and `spill_o`=0. The recency order starts with way 0 as the most recent and way 7 as the least recent.
- R2: If any way is invalid, the victim is the lowest-indexed invalid way and `victim_valid_o`=0.
- R3: If all ways are valid and at least one has status 0 (replicate), the victim is a replicate.
- R4: Within the chosen class the victim is the least recently used way. If all ways are valid singlets (status 1), the victim is the least recently used singlet.
- R5: `spill_o`=1 exactly when the victim is valid and has status 1 (singlet). A replicate victim or an invalid victim gives `spill_o`=0.
- R6: A hit or a fill on a way makes that way the most recently used from the clock edge after the strobe. The victim outputs follow the state with no further delay.
- R7: A snoop sets the addressed way's status to `snp_singlet_i` on the next edge. A snoop does not change the recency order or the valid bits.
- R8: A fill and a snoop to the same way in the same cycle leave the way valid with the status given by `fill_singlet_i`.
- R9: If a fill and a hit arrive in the same cycle, only the fill way becomes the most recently used. The hit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 1 | Hit strobe |
| hit_way_i | input | 3 | Way that hit |
| fill_i | input | 1 | Fill strobe; the way becomes valid |
| fill_way_i | input | 3 | Way being filled |
| fill_singlet_i | input | 1 | Status of the filled line (1 = singlet, 0 = replicate) |
| snp_i | input | 1 | Status update strobe from a snoop |
| snp_way_i | input | 3 | Way whose status is updated |
| snp_singlet_i | input | 1 | New status (1 = singlet, 0 = replicate) |
| victim_way_o | output | 3 | Way to evict |
| victim_valid_o | output | 1 | Victim way holds a valid line |
| spill_o | output | 1 | Victim is a valid singlet and may be spilled |

## Verification
The bench goes after four corner cases, each with a distinct wrong behaviour:

- A set with only one replicate among old singlets. A selector that ignores status would evict the older singlet and needlessly lose the only on-chip copy.
- Snoops that flip status back and forth. If a snoop disturbed the recency order, the least recently used way would move after the status is restored.
- A fill colliding with a snoop or a hit on the same cycle. Giving the wrong input priority would either leave the filled line with stale status or make the hit way the most recent.
- Free ways at mixed positions. A design that scans in the wrong order, or treats invalid lines as candidates for spilling, would report the wrong way or a false spill.

// File: rtl/rvs_pkg.sv
package rvs_pkg;
  typedef enum logic {
    ST_REPLICATE = 1'b0,
    ST_SINGLET   = 1'b1
  } share_st_e;
endpackage

// File: rtl/rvs_lru_ages.sv
module rvs_lru_ages #(
  parameter int WAYS  = 8,
  parameter int AGE_W = $clog2(WAYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        touch_i,
  input  logic [AGE_W-1:0]            touch_way_i,
  output logic [WAYS-1:0][AGE_W-1:0]  ages_o
);
  logic [WAYS-1:0][AGE_W-1:0] age_q;
  logic [AGE_W-1:0]           touch_age;

  assign touch_age = age_q[touch_way_i];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[g] <= AGE_W'(g);
      end else if (touch_i) begin
        if (touch_way_i == AGE_W'(g)) age_q[g] <= '0;
        else if (age_q[g] < touch_age) age_q[g] <= age_q[g] + AGE_W'(1);
      end
    end
  end

  assign ages_o = age_q;
endmodule

// File: rtl/rvs_status.sv
module rvs_status
  import rvs_pkg::*;
#(
  parameter int WAYS  = 8,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic             fill_singlet_i,
  input  logic             snp_i,
  input  logic [WAY_W-1:0] snp_way_i,
  input  logic             snp_singlet_i,
  output logic [WAYS-1:0]  valid_o,
  output logic [WAYS-1:0]  singlet_o
);
  logic [WAYS-1:0] valid_q;
  share_st_e       st_q [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic fill_hit, snp_hit;
    assign fill_hit = fill_i && (fill_way_i == WAY_W'(g));
    assign snp_hit  = snp_i && (snp_way_i == WAY_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        st_q[g]    <= ST_SINGLET;
      end else begin
        if (fill_hit) valid_q[g] <= 1'b1;
        // fill overrides a same-cycle snoop
        if (fill_hit)     st_q[g] <= share_st_e'(fill_singlet_i);
        else if (snp_hit) st_q[g] <= share_st_e'(snp_singlet_i);
      end
    end

    assign singlet_o[g] = (st_q[g] == ST_SINGLET);
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/rvs_pick.sv
module rvs_pick #(
  parameter int WAYS  = 8,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid_i,
  input  logic [WAYS-1:0]             singlet_i,
  input  logic [WAYS-1:0][WAY_W-1:0]  ages_i,
  output logic [WAY_W-1:0]            victim_way_o,
  output logic                        victim_valid_o,
  output logic                        victim_singlet_o
);
  logic             have_inv, have_repl, found;
  logic [WAY_W-1:0] inv_idx, old_idx, best_age;
  logic [WAYS-1:0]  cand;

  always_comb begin
    have_inv = 1'b0;
    inv_idx  = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        have_inv = 1'b1;
        inv_idx  = WAY_W'(i);
      end
    end
  end

  assign have_repl = |(valid_i & ~singlet_i);
  assign cand      = have_repl ? (valid_i & ~singlet_i) : valid_i;

  always_comb begin
    found    = 1'b0;
    old_idx  = '0;
    best_age = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (cand[i] && (!found || ages_i[i] > best_age)) begin
        found    = 1'b1;
        old_idx  = WAY_W'(i);
        best_age = ages_i[i];
      end
    end
  end

  assign victim_way_o     = have_inv ? inv_idx : old_idx;
  assign victim_valid_o   = !have_inv;
  assign victim_singlet_o = !have_inv && !have_repl;
endmodule

// File: rtl/repl_victim_sel.sv
module repl_victim_sel #(
  parameter int WAYS  = 8,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic             fill_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic             fill_singlet_i,
  input  logic             snp_i,
  input  logic [WAY_W-1:0] snp_way_i,
  input  logic             snp_singlet_i,
  output logic [WAY_W-1:0] victim_way_o,
  output logic             victim_valid_o,
  output logic             spill_o
);
  logic                       touch;
  logic [WAY_W-1:0]           touch_way;
  logic [WAYS-1:0]            valid_w, singlet_w;
  logic [WAYS-1:0][WAY_W-1:0] age_w;
  logic                       vic_singlet;

  // fill takes the recency update over a hit
  assign touch     = fill_i | hit_i;
  assign touch_way = fill_i ? fill_way_i : hit_way_i;

  rvs_lru_ages #(.WAYS(WAYS), .AGE_W(WAY_W)) u_ages (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .touch_way_i (touch_way),
    .ages_o      (age_w)
  );

  rvs_status #(.WAYS(WAYS), .WAY_W(WAY_W)) u_status (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .fill_i         (fill_i),
    .fill_way_i     (fill_way_i),
    .fill_singlet_i (fill_singlet_i),
    .snp_i          (snp_i),
    .snp_way_i      (snp_way_i),
    .snp_singlet_i  (snp_singlet_i),
    .valid_o        (valid_w),
    .singlet_o      (singlet_w)
  );

  rvs_pick #(.WAYS(WAYS), .WAY_W(WAY_W)) u_pick (
    .valid_i          (valid_w),
    .singlet_i        (singlet_w),
    .ages_i           (age_w),
    .victim_way_o     (victim_way_o),
    .victim_valid_o   (victim_valid_o),
    .victim_singlet_o (vic_singlet)
  );

  assign spill_o = vic_singlet;
endmodule

// File: rtl/rvs_chk.sv
module rvs_chk #(
  parameter int WAYS  = 8,
  parameter int WAY_W = $clog2(WAYS)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       hit_i,
  input logic [WAY_W-1:0]           hit_way_i,
  input logic                       fill_i,
  input logic [WAY_W-1:0]           fill_way_i,
  input logic                       fill_singlet_i,
  input logic [WAYS-1:0]            valid_i,
  input logic [WAYS-1:0]            singlet_i,
  input logic [WAYS-1:0][WAY_W-1:0] age_i,
  input logic [WAY_W-1:0]           victim_way_o,
  input logic                       victim_valid_o,
  input logic                       spill_o
);
  logic repl_any, oldest_ok;

  assign repl_any = |(valid_i & ~singlet_i);

  always_comb begin
    oldest_ok = 1'b1;
    for (int i = 0; i < WAYS; i++) begin
      if (WAY_W'(i) != victim_way_o && valid_i[i] &&
          (!repl_any || !singlet_i[i]) && age_i[i] >= age_i[victim_way_o])
        oldest_ok = 1'b0;
    end
  end

  a_r2_free_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&valid_i)) |-> (!victim_valid_o && !valid_i[victim_way_o]));

  a_r3_replicate_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&valid_i) && repl_any) |-> !singlet_i[victim_way_o]);

  a_r4_oldest_in_class: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_valid_o |-> oldest_ok);

  a_r5_spill_valid_singlet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spill_o == (victim_valid_o && singlet_i[victim_way_o]));

  a_r6_fill_mru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> age_i[$past(fill_way_i)] == '0);

  a_r9_hit_mru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && !fill_i) |=> age_i[$past(hit_way_i)] == '0);

  a_r8_fill_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> (valid_i[$past(fill_way_i)] &&
                singlet_i[$past(fill_way_i)] == $past(fill_singlet_i)));
endmodule

bind repl_victim_sel rvs_chk #(.WAYS(WAYS), .WAY_W(WAY_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .hit_i          (hit_i),
  .hit_way_i      (hit_way_i),
  .fill_i         (fill_i),
  .fill_way_i     (fill_way_i),
  .fill_singlet_i (fill_singlet_i),
  .valid_i        (valid_w),
  .singlet_i      (singlet_w),
  .age_i          (age_w),
  .victim_way_o   (victim_way_o),
  .victim_valid_o (victim_valid_o),
  .spill_o        (spill_o)
);

// File: tb/repl_victim_sel_test.sv
`timescale 1ns/1ps
module repl_victim_sel_test;
  localparam int WAYS  = 8;
  localparam int WAY_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hit = 1'b0, fill = 1'b0, fill_s = 1'b0, snp = 1'b0, snp_s = 1'b0;
  logic [WAY_W-1:0] hit_w = '0, fill_w = '0, snp_w = '0;
  logic [WAY_W-1:0] vic_w;
  logic vic_v, spill;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // model: recency list, index 0 = most recent
  int  order [WAYS];
  bit  m_valid [WAYS];
  bit  m_sing [WAYS];

  always #4 clk = ~clk;

  repl_victim_sel #(.WAYS(WAYS)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .hit_i(hit), .hit_way_i(hit_w),
    .fill_i(fill), .fill_way_i(fill_w), .fill_singlet_i(fill_s),
    .snp_i(snp), .snp_way_i(snp_w), .snp_singlet_i(snp_s),
    .victim_way_o(vic_w), .victim_valid_o(vic_v), .spill_o(spill)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int i = 0; i < WAYS; i++) begin
      order[i] = i; m_valid[i] = 0; m_sing[i] = 1;
    end
  endtask

  task automatic m_touch(int w);
    int p = 0;
    for (int k = 0; k < WAYS; k++) if (order[k] == w) p = k;
    for (int k = p; k > 0; k--) order[k] = order[k-1];
    order[0] = w;
  endtask

  task automatic m_expect(output int ew, output int ev, output int es);
    ew = -1;
    for (int i = WAYS - 1; i >= 0; i--) if (!m_valid[i]) ew = i;
    if (ew >= 0) begin ev = 0; es = 0; return; end
    ev = 1;
    for (int k = WAYS - 1; k >= 0; k--)
      if (ew < 0 && !m_sing[order[k]]) ew = order[k];
    if (ew >= 0) begin es = 0; return; end
    ew = order[WAYS-1]; es = 1;
  endtask

  task automatic cmp_all(string req);
    int ew, ev, es;
    m_expect(ew, ev, es);
    chk(req, "victim_way", int'(vic_w), ew);
    chk(req, "victim_valid", int'(vic_v), ev);
    chk("R5", "spill", int'(spill), es);
  endtask

  function automatic string auto_tag();
    bit all_v = 1, any_r = 0;
    for (int i = 0; i < WAYS; i++) begin
      if (!m_valid[i]) all_v = 0;
      else if (!m_sing[i]) any_r = 1;
    end
    return !all_v ? "R2" : (any_r ? "R3" : "R4");
  endfunction

  // one clock: model follows inputs at the edge, compare at the falling edge
  task automatic step(string req);
    @(posedge clk);
    if (snp) m_sing[snp_w] = snp_s;
    if (fill) begin
      m_valid[fill_w] = 1; m_sing[fill_w] = fill_s; m_touch(fill_w);
    end else if (hit) m_touch(hit_w);
    @(negedge clk);
    hit = 0; fill = 0; snp = 0;
    cmp_all(req);
  endtask

  task automatic do_fill(int w, bit s);
    fill = 1; fill_w = WAY_W'(w); fill_s = s;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int ew, ev, es;
    m_reset();
    repeat (3) @(negedge clk);
    cmp_all("R1");
    chk("R1", "reset victim", int'(vic_w), 0);
    rst_n = 1;
    @(negedge clk);
    cmp_all("R1");

    // R2: fill the victim way each time until the set is full
    for (int i = 0; i < WAYS; i++) begin
      m_expect(ew, ev, es);
      chk("R2", "free way", ew, i);
      do_fill(ew, 1);
      step("R2");
    end
    // R4: all valid singlets, way 0 oldest
    chk("R4", "lru singlet", int'(vic_w), 0);
    chk("R5", "spill singlet", int'(spill), 1);

    // R6: hit way 0 moves the victim to way 1
    hit = 1; hit_w = 0;
    step("R6");
    chk("R6", "after hit", int'(vic_w), 1);

    // R7/R3: way 5 becomes a replicate and is picked although young
    snp = 1; snp_w = 5; snp_s = 0;
    step("R7");
    chk("R3", "replicate chosen", int'(vic_w), 5);
    chk("R5", "no spill replicate", int'(spill), 0);
    snp = 1; snp_w = 5; snp_s = 1;
    step("R7");
    chk("R7", "recency untouched", int'(vic_w), 1);

    // R8: fill and snoop collide on way 3
    do_fill(3, 0); snp = 1; snp_w = 3; snp_s = 1;
    step("R8");
    chk("R8", "fill status wins", int'(vic_w), 3);

    // R9: fill way 3 as singlet while hitting way 1
    do_fill(3, 1); hit = 1; hit_w = 1;
    step("R9");
    chk("R9", "hit ignored", int'(vic_w), 1);

    // R4: two replicates, the older one is chosen
    snp = 1; snp_w = 2; snp_s = 0; step("R4");
    snp = 1; snp_w = 6; snp_s = 0; step("R4");
    chk("R4", "older replicate", int'(vic_w), 2);
    hit = 1; hit_w = 2; step("R4");
    chk("R4", "other replicate", int'(vic_w), 6);

    // random sweep with resets sprinkled in
    for (int c = 0; c < 4000; c++) begin
      if (c % 997 == 996) begin
        rst_n = 0; m_reset();
        @(negedge clk); cmp_all("R1");
        rst_n = 1; @(negedge clk);
      end
      hit   = ($urandom % 3) == 0; hit_w = WAY_W'($urandom);
      fill  = ($urandom % 4) == 0;
      m_expect(ew, ev, es);
      fill_w = ($urandom % 2) ? WAY_W'(ew) : WAY_W'($urandom);
      fill_s = $urandom % 2;
      snp   = ($urandom % 3) == 0; snp_w = WAY_W'($urandom); snp_s = $urandom % 2;
      step(auto_tag());
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule